// File: doc/BRIEF.md
# Performance Level Voltage Controller

This block sits between a power management unit and an external supply. It takes a requested performance level, turns it into a binary voltage code for the supply, and tells the clock side which level is safe to use. Both the request and the current-level output are thermometer coded. A level of k is written as k ones packed into the low bits. An all-zero pattern is the retention sleep level. The number of levels is a parameter of at most eight.

A transition finishes in one of two open-loop modes. In timed mode the block waits a programmed settling interval. In polled mode it waits for the supply's voltage-ok indication. While a polled raise is in progress, the block also follows intermediate stable levels that the supply reports. When the level goes up, the voltage moves first and the clock side is told last. When the level goes down, the clock side is told first and the voltage follows. A request that arrives during a transition is held, and it is applied once the transition completes. A constant revision value lets driver software check compatibility.

Top module: `perf_volt_ctrl`

## Requirements
- R1: After reset, curLevel is 8'h01 (level 1), voltCode is 1, busy is 0, reqErr is 0.
- R2: A request on reqLevel is sampled when reqValid is high. The pattern with k ones in bits [k-1:0] means level k, and voltCode carries level k as the binary value k.
- R3: A request pattern that has a 0 below a 1 is ignored, so curLevel, voltCode and busy do not change. reqErr is set in the cycle after the request and stays set until reset.
- R4: In timed mode, a raise puts the new voltCode on the second clock edge after the request is sampled. curLevel and busy follow settleTime+1 edges later.
- R5: A lowering updates curLevel on the second edge after the request is sampled, and voltCode one edge later. busy clears settleTime+1 edges after voltCode changes (timed mode).
- R6: In polled mode (pollMode=1), a transition stays in progress while supplyOk is 0. It completes on the first edge that sees supplyOk high.
- R7: During a polled raise, a supplyLevel strictly above the current level and strictly below the target moves curLevel up to supplyLevel.
- R8: Requests that arrive during a transition are held and applied after it completes. When several arrive, the latest one wins.
- R9: The level shown on curLevel is never above voltCode.
- R10: revId always equals the REV_ID parameter (default 8'h21).
- R11: A request for the current level changes nothing, and busy stays 0.
- R12: The all-zero request is the retention level: curLevel becomes 8'h00 and voltCode becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqLevel | input | NUM_LEVELS | Requested level, thermometer coded |
| reqValid | input | 1 | Request strobe |
| pollMode | input | 1 | 1 = wait for supplyOk, 0 = timed wait |
| settleTime | input | TIMER_W | Settling interval in cycles |
| supplyOk | input | 1 | Supply voltage-ok indication |
| supplyLevel | input | clog2(NUM_LEVELS+1) | Stable level reported by the supply |
| curLevel | output | NUM_LEVELS | Level safe for the clock side, thermometer coded |
| voltCode | output | clog2(NUM_LEVELS+1) | Voltage code sent to the supply |
| busy | output | 1 | Transition in progress |
| reqErr | output | 1 | Sticky malformed-request flag |
| revId | output | 8 | Revision identifier |

## Verification
Some properties are checked on every cycle. These are: the voltage never sits below the advertised level, the error flag never clears, a polled raise cannot finish while voltage-ok is low, and each intermediate step moves strictly upward and stays below the target. Other behaviour can only be shown by bench scenarios. This includes the exact edge counts of timed raises and lowerings, and that queued requests are dropped in favour of the newest. It also includes that malformed or same-level requests leave the outputs alone, and the order of the level and voltage updates when lowering.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_UP = 2'd1,
    ST_DROP    = 2'd2,
    ST_WAIT_DN = 2'd3
  } pvcState_e;

  typedef struct packed {
    logic takeUp;
    logic takeDown;
    logic takeSame;
    logic dropVolt;
    logic tick;
    logic commit;
    logic step;
  } pvcStrobe_t;
endpackage

// File: rtl/pvc_datapath.sv
module pvc_datapath #(
  parameter int NUM_LEVELS = 8,
  parameter int TIMER_W    = 16,
  parameter int LW         = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqCode,
  input  logic                  reqValid,
  input  logic [TIMER_W-1:0]    settleTime,
  input  logic [LW-1:0]         supplyLevel,
  input  pvc_pkg::pvcStrobe_t   strb,
  output logic                  pendValid,
  output logic                  pendUp,
  output logic                  pendDown,
  output logic                  timerZero,
  output logic                  stepAvail,
  output logic [NUM_LEVELS-1:0] curTherm,
  output logic [LW-1:0]         voltCode,
  output logic                  reqErr
);
  logic [LW-1:0]      pendLvl, tgtLvl, curLvl, voltLvl, reqCnt;
  logic [NUM_LEVELS-1:0] reqExp;
  logic [TIMER_W-1:0] timer;
  logic               codeOk, errFlag, anyTake;

  always_comb begin
    reqCnt = '0;
    for (int i = 0; i < NUM_LEVELS; i++) reqCnt = reqCnt + LW'(reqCode[i]);
    for (int i = 0; i < NUM_LEVELS; i++) reqExp[i] = (LW'(i) < reqCnt);
  end
  assign codeOk  = (reqExp == reqCode);
  assign anyTake = strb.takeUp | strb.takeDown | strb.takeSame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendLvl   <= LW'(1);
      errFlag   <= 1'b0;
    end else begin
      if (reqValid && codeOk) begin
        pendValid <= 1'b1;
        pendLvl   <= reqCnt;
      end else if (anyTake) begin
        pendValid <= 1'b0;
      end
      if (reqValid && !codeOk) errFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtLvl  <= LW'(1);
      curLvl  <= LW'(1);
      voltLvl <= LW'(1);
      timer   <= '0;
    end else begin
      if (strb.takeUp || strb.takeDown) tgtLvl <= pendLvl;
      if (strb.takeUp)        voltLvl <= pendLvl;
      else if (strb.dropVolt) voltLvl <= tgtLvl;
      if (strb.takeDown)    curLvl <= pendLvl;
      else if (strb.commit) curLvl <= tgtLvl;
      else if (strb.step)   curLvl <= supplyLevel;
      if (strb.takeUp || strb.dropVolt) timer <= settleTime;
      else if (strb.tick && timer != '0) timer <= timer - 1'b1;
    end
  end

  assign pendUp    = pendLvl > curLvl;
  assign pendDown  = pendLvl < curLvl;
  assign timerZero = (timer == '0);
  assign stepAvail = (supplyLevel > curLvl) && (supplyLevel < tgtLvl);
  assign voltCode  = voltLvl;
  assign reqErr    = errFlag;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gTherm
    assign curTherm[g] = (curLvl > LW'(g));
  end

  // R9
  safe_volt_chk: assert property (@(posedge clk) disable iff (!rstN)
    curLvl <= voltLvl);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R7
  track_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (curLvl < tgtLvl) && (curLvl > $past(curLvl)));
endmodule

// File: rtl/pvc_control.sv
module pvc_control (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pollMode,
  input  logic                supplyOk,
  input  logic                pendValid,
  input  logic                pendUp,
  input  logic                pendDown,
  input  logic                timerZero,
  input  logic                stepAvail,
  output pvc_pkg::pvcStrobe_t strb,
  output logic                busy
);
  import pvc_pkg::*;

  pvcState_e state, nxt;
  logic      done;

  assign done = pollMode ? supplyOk : timerZero;

  always_comb begin
    strb = '0;
    nxt  = state;
    unique case (state)
      ST_IDLE: if (pendValid) begin
        if (pendUp) begin
          strb.takeUp = 1'b1;
          nxt = ST_WAIT_UP;
        end else if (pendDown) begin
          strb.takeDown = 1'b1;
          nxt = ST_DROP;
        end else begin
          strb.takeSame = 1'b1;
        end
      end
      ST_WAIT_UP: if (done) begin
        strb.commit = 1'b1;
        nxt = ST_IDLE;
      end else begin
        strb.tick = 1'b1;
        strb.step = pollMode && stepAvail;
      end
      ST_DROP: begin
        strb.dropVolt = 1'b1;
        nxt = ST_WAIT_DN;
      end
      ST_WAIT_DN: if (done) nxt = ST_IDLE;
                  else strb.tick = 1'b1;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != ST_IDLE);

  // R6
  poll_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_UP && pollMode && !supplyOk) |=> (state == ST_WAIT_UP));
endmodule

// File: rtl/perf_volt_ctrl.sv
module perf_volt_ctrl #(
  parameter int         NUM_LEVELS = 8,
  parameter int         TIMER_W    = 16,
  parameter logic [7:0] REV_ID     = 8'h21
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_LEVELS-1:0]              reqLevel,
  input  logic                               reqValid,
  input  logic                               pollMode,
  input  logic [TIMER_W-1:0]                 settleTime,
  input  logic                               supplyOk,
  input  logic [$clog2(NUM_LEVELS+1)-1:0]    supplyLevel,
  output logic [NUM_LEVELS-1:0]              curLevel,
  output logic [$clog2(NUM_LEVELS+1)-1:0]    voltCode,
  output logic                               busy,
  output logic                               reqErr,
  output logic [7:0]                         revId
);
  localparam int LW = $clog2(NUM_LEVELS + 1);

  pvc_pkg::pvcStrobe_t strb;
  logic pendValid, pendUp, pendDown, timerZero, stepAvail;

  pvc_datapath #(.NUM_LEVELS(NUM_LEVELS), .TIMER_W(TIMER_W), .LW(LW)) u_dp (
    .clk, .rstN,
    .reqCode(reqLevel), .reqValid, .settleTime, .supplyLevel, .strb,
    .pendValid, .pendUp, .pendDown, .timerZero, .stepAvail,
    .curTherm(curLevel), .voltCode, .reqErr
  );

  pvc_control u_ctl (
    .clk, .rstN, .pollMode, .supplyOk,
    .pendValid, .pendUp, .pendDown, .timerZero, .stepAvail,
    .strb, .busy
  );

  assign revId = REV_ID;
endmodule

// File: tb/perf_volt_ctrl_tb.sv
module perf_volt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  reqLevel = '0;
  logic        reqValid = 1'b0;
  logic        pollMode = 1'b0;
  logic [15:0] settleTime = '0;
  logic        supplyOk = 1'b0;
  logic [3:0]  supplyLevel = 4'd1;
  logic [7:0]  curLevel;
  logic [3:0]  voltCode;
  logic        busy, reqErr;
  logic [7:0]  revId;

  int total = 0;
  int bad = 0;
  int orderBad = 0;

  always #10 clk = ~clk;

  perf_volt_ctrl u_dut (
    .clk, .rstN, .reqLevel, .reqValid, .pollMode, .settleTime, .supplyOk,
    .supplyLevel, .curLevel, .voltCode, .busy, .reqErr, .revId
  );

  // {request, settle, expected level, expected voltage}
  localparam logic [35:0] VEC [7] = '{
    {8'h0F, 16'd3, 8'h0F, 4'd4},
    {8'hFF, 16'd0, 8'hFF, 4'd8},
    {8'h03, 16'd5, 8'h03, 4'd2},
    {8'h00, 16'd2, 8'h00, 4'd0},
    {8'h01, 16'd1, 8'h01, 4'd1},
    {8'h01, 16'd1, 8'h01, 4'd1},
    {8'h07, 16'd4, 8'h07, 4'd3}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendReq(input logic [7:0] code);
    reqLevel = code;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    @(negedge clk);
    while (busy && guard < 2000) begin
      if ($countones(curLevel) > voltCode) orderBad++;
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1, R10
    check("R1 level", curLevel, 8'h01);
    check("R1 volt", voltCode, 4'd1);
    check("R1 busy", busy, 0);
    check("R1 err", reqErr, 0);
    check("R10 rev", revId, 8'h21);

    // R2, R12, R11 via table
    for (int i = 0; i < 7; i++) begin
      settleTime = VEC[i][27:12];
      sendReq(VEC[i][35:28]);
      waitIdle();
      check($sformatf("R2 vec%0d level", i), curLevel, VEC[i][11:4]);
      check($sformatf("R2 vec%0d volt", i), voltCode, VEC[i][3:0]);
    end
    check("R9 order during table", orderBad, 0);

    // R4 timed raise 07 -> FF, settle 3
    settleTime = 16'd3;
    sendReq(8'hFF);
    @(negedge clk);
    check("R4 volt first", voltCode, 4'd8);
    check("R4 level held", curLevel, 8'h07);
    check("R4 busy", busy, 1);
    repeat (3) @(negedge clk);
    check("R4 level before settle", curLevel, 8'h07);
    @(negedge clk);
    check("R4 level after settle", curLevel, 8'hFF);
    check("R4 idle", busy, 0);

    // R5 timed lowering FF -> 03, settle 2
    settleTime = 16'd2;
    sendReq(8'h03);
    @(negedge clk);
    check("R5 level first", curLevel, 8'h03);
    check("R5 volt held", voltCode, 4'd8);
    @(negedge clk);
    check("R5 volt drop", voltCode, 4'd2);
    repeat (2) @(negedge clk);
    check("R5 still busy", busy, 1);
    @(negedge clk);
    check("R5 done", busy, 0);

    // R3 malformed request
    sendReq(8'h05);
    check("R3 err set", reqErr, 1);
    @(negedge clk);
    check("R3 level kept", curLevel, 8'h03);
    check("R3 volt kept", voltCode, 4'd2);
    check("R3 no busy", busy, 0);

    // R8 queued requests, latest wins
    settleTime = 16'd6;
    sendReq(8'h0F);
    sendReq(8'h3F);
    sendReq(8'h7F);
    waitIdle();
    check("R8 first applied", curLevel, 8'h0F);
    waitIdle();
    check("R8 latest applied", curLevel, 8'h7F);
    check("R8 volt", voltCode, 4'd7);
    check("R3 err sticky", reqErr, 1);

    // R6 polled lowering 7F -> 01
    pollMode = 1'b1;
    settleTime = 16'd0;
    supplyOk = 1'b0;
    sendReq(8'h01);
    @(negedge clk);
    check("R6 lower level first", curLevel, 8'h01);
    @(negedge clk);
    check("R6 lower volt", voltCode, 4'd1);
    repeat (4) @(negedge clk);
    check("R6 waits for ok", busy, 1);
    supplyOk = 1'b1;
    @(negedge clk);
    check("R6 lower done", busy, 0);
    supplyOk = 1'b0;

    // R6, R7 polled raise 01 -> FF with intermediate steps
    supplyLevel = 4'd1;
    sendReq(8'hFF);
    @(negedge clk);
    check("R6 raise volt", voltCode, 4'd8);
    repeat (3) @(negedge clk);
    check("R6 raise holds", curLevel, 8'h01);
    supplyLevel = 4'd4;
    @(negedge clk);
    check("R7 step to 4", curLevel, 8'h0F);
    supplyLevel = 4'd6;
    @(negedge clk);
    check("R7 step to 6", curLevel, 8'h3F);
    supplyLevel = 4'd8;
    @(negedge clk);
    check("R7 no step at target", curLevel, 8'h3F);
    check("R7 still busy", busy, 1);
    supplyOk = 1'b1;
    @(negedge clk);
    check("R6 raise done", curLevel, 8'hFF);
    check("R6 raise idle", busy, 0);

    // R11 same-level request
    sendReq(8'hFF);
    @(negedge clk);
    check("R11 no busy", busy, 0);
    check("R11 level kept", curLevel, 8'hFF);
    check("R11 volt kept", voltCode, 4'd8);
    check("R9 order overall", orderBad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule